// File: doc/BRIEF.md
# Interrupt-Aware Instruction Cycle Sequencer

This block is the control sequencer of a small accumulator processor. It walks each instruction through a fixed series of stages. First it issues the program counter as the fetch address, and the returned word is latched as the instruction. The sequencer then decodes it, forms the operand address and reads the operand. After that it performs the data operation and, for a store, writes the accumulator back. Every instruction ends with an interrupt check. Memory is a simple synchronous port: read data appears on the cycle after a read strobe.

Interrupt requests arrive as prioritised level-sensitive lines, and a higher line index means a higher priority. An accepted request gets a one-cycle acknowledge on its own line. On entry, the program counter, accumulator, interrupt-enable flag and current priority level are pushed onto a four-entry internal stack. The program counter is then loaded from that line's slot of a handler-vector input. A return opcode pops the context. A mode input selects between two behaviours. In sequential mode, interrupts are masked while a handler runs. In nested mode, a strictly higher-priority request may preempt the running handler.

Top module: `icycle_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the block drives a read of address 0. No write and no acknowledge are asserted. The accumulator starts at zero.
- R2: An instruction is 16 bits. Bits 15:8 hold the opcode and bits 7:0 hold an operand address. The opcodes are 0x01 load (the accumulator takes the operand), 0x02 add (the accumulator takes accumulator plus operand, modulo 2^16), 0x03 store (the accumulator is written to the address), 0x04 jump and 0x05 return-from-interrupt. Any other opcode does nothing.
- R3: Each instruction takes exactly 8 cycles. The instruction read is issued in cycle 0 and the operand read, for load and add only, in cycle 3. The store write is issued in cycle 6, and cycle 7 is the interrupt check. A read and a write are never issued in the same cycle.
- R4: The program counter advances by one after each fetch. A jump replaces it with the operand address.
- R5: At the interrupt check, if a request is accepted, the highest-index asserted line is taken. Context is pushed and the program counter is loaded from bits [8i+7:8i] of the vector input for line i.
- R6: The acknowledge for an accepted line is high for exactly one cycle, the cycle that fetches the handler's first instruction.
- R7: Return-from-interrupt restores the program counter, accumulator, enable flag and level that were saved. With an empty stack it does nothing.
- R8: In sequential mode (nested_mode=0), no interrupt is taken while a handler runs. Requests that are still pending are taken one after another, after each return.
- R9: In nested mode, a request whose level (index+1) is strictly greater than the running level preempts the handler. The handler resumes with its context intact.
- R10: The stack holds 4 entries. A request that would push a fifth entry stays pending until a return frees a slot.
- R11: At most one acknowledge line is high at a time, and only for a line that was requesting in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nested_mode | input | 1 | 1 = priority preemption, 0 = masked sequential servicing |
| irq_req | input | 8 | Level-sensitive interrupt requests, higher index wins |
| vec_tbl | input | 64 | Handler start address for each line, 8 bits per line |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 16 | Write data (accumulator) |
| irq_ack | output | 8 | One-cycle acknowledge per accepted line |

## Verification
The assertions assume that a request line stays asserted until its acknowledge has been seen, and that a source then drops it before the next interrupt check. The acknowledge-source check also assumes the vector input and mode are stable while a handler runs. The bench keeps within this because its requests are driven only on falling edges. A request is removed in the same half cycle that its acknowledge is observed. Mode and vectors change only while reset is held.

// File: rtl/icycle_seq.sv
module icycle_seq #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int NIRQ  = 8,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nested_mode,
  input  logic [NIRQ-1:0]    irq_req,
  input  logic [NIRQ*AW-1:0] vec_tbl,
  input  logic [DW-1:0]      mem_rdata,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic [NIRQ-1:0]    irq_ack
);
  localparam int LW   = $clog2(NIRQ + 1);
  localparam int IW   = $clog2(NIRQ);
  localparam int SPW  = $clog2(DEPTH + 1);
  localparam int IDXW = $clog2(DEPTH);
  localparam logic [7:0] OP_LOAD = 8'h01, OP_ADD = 8'h02, OP_STORE = 8'h03,
                         OP_JUMP = 8'h04, OP_RETI = 8'h05;

  typedef enum logic [2:0] {
    S_ADDR, S_FETCH, S_DEC, S_OPADDR, S_OPFETCH, S_EXEC, S_STORE, S_ICHECK
  } st_t;

  st_t             st;
  logic [AW-1:0]   pc;
  logic [DW-1:0]   ir, opnd, acc;
  logic            ien;
  logic [LW-1:0]   lvl;
  logic [SPW-1:0]  sp;

  logic [AW-1:0]   stk_pc  [DEPTH];
  logic [DW-1:0]   stk_acc [DEPTH];
  logic            stk_ien [DEPTH];
  logic [LW-1:0]   stk_lvl [DEPTH];

  wire [7:0]      opc      = ir[DW-1 -: 8];
  wire [AW-1:0]   oaddr    = ir[AW-1:0];
  wire            need_opd = (opc == OP_LOAD) || (opc == OP_ADD);
  wire [IDXW-1:0] push_idx = IDXW'(sp);
  wire [IDXW-1:0] top_idx  = IDXW'(sp - SPW'(1));

  logic          any;
  logic [IW-1:0] best;
  always_comb begin
    any  = 1'b0;
    best = '0;
    for (int i = 0; i < NIRQ; i++)
      if (irq_req[i]) begin
        any  = 1'b1;
        best = IW'(i);
      end
  end

  wire [LW-1:0] best_lvl = LW'(best) + LW'(1);
  wire take = any && ien && (sp < SPW'(DEPTH)) && (!nested_mode || best_lvl > lvl);

  assign mem_rd    = (st == S_ADDR) || (st == S_OPADDR && need_opd);
  assign mem_wr    = (st == S_STORE) && (opc == OP_STORE);
  assign mem_addr  = (st == S_ADDR) ? pc : oaddr;
  assign mem_wdata = acc;

  always_ff @(posedge clk) begin
    if (st == S_ICHECK && take) begin
      stk_pc[push_idx]  <= pc;
      stk_acc[push_idx] <= acc;
      stk_ien[push_idx] <= ien;
      stk_lvl[push_idx] <= lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_ADDR;
      pc      <= '0;
      ir      <= '0;
      opnd    <= '0;
      acc     <= '0;
      ien     <= 1'b1;
      lvl     <= '0;
      sp      <= '0;
      irq_ack <= '0;
    end else begin
      irq_ack <= '0;
      case (st)
        S_ADDR:    st <= S_FETCH;
        S_FETCH: begin
          ir <= mem_rdata;
          pc <= pc + AW'(1);
          st <= S_DEC;
        end
        S_DEC:     st <= S_OPADDR;
        S_OPADDR:  st <= S_OPFETCH;
        S_OPFETCH: begin
          if (need_opd) opnd <= mem_rdata;
          st <= S_EXEC;
        end
        S_EXEC: begin
          case (opc)
            OP_LOAD: acc <= opnd;
            OP_ADD:  acc <= acc + opnd;
            OP_JUMP: pc  <= oaddr;
            OP_RETI:
              if (sp != '0) begin
                pc  <= stk_pc[top_idx];
                acc <= stk_acc[top_idx];
                ien <= stk_ien[top_idx];
                lvl <= stk_lvl[top_idx];
                sp  <= sp - SPW'(1);
              end
            default: ;
          endcase
          st <= S_STORE;
        end
        S_STORE:   st <= S_ICHECK;
        default: begin
          if (take) begin
            sp      <= sp + SPW'(1);
            pc      <= vec_tbl[best*AW +: AW];
            ien     <= nested_mode;
            lvl     <= best_lvl;
            irq_ack <= NIRQ'(1) << best;
          end
          st <= S_ADDR;
        end
      endcase
    end
  end
endmodule

// File: rtl/icycle_seq_chk.sv
module icycle_seq_chk #(
  parameter int NIRQ  = 8,
  parameter int SPW   = 3,
  parameter int DEPTH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NIRQ-1:0] irq_req,
  input logic [NIRQ-1:0] irq_ack,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic [SPW-1:0]  sp
);
  p_ack_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));

  p_ack_requested_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> ((irq_ack & $past(irq_req)) == irq_ack));

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |=> (irq_ack == '0));

  p_rw_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_stack_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));

  p_ack_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |-> (sp == SPW'($past(sp) + 1)));
endmodule

bind icycle_seq icycle_seq_chk #(.NIRQ(NIRQ), .SPW(SPW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .sp(sp)
);

// File: tb/icycle_seq_test.sv
`timescale 1ns/1ps
module icycle_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nested_mode = 1'b0;
  logic [7:0]  irq_req = '0;
  logic [63:0] vec_tbl;
  logic [15:0] mem_rdata;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_addr, irq_ack;
  logic [15:0] mem_wdata;

  icycle_seq uut (.clk(clk), .rst_n(rst_n), .nested_mode(nested_mode), .irq_req(irq_req),
    .vec_tbl(vec_tbl), .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq_ack(irq_ack));

  always #4 clk = ~clk;

  logic [15:0] mem [256];
  int wlog [16];
  int wn;
  int alog [16];
  int an;
  int chain_max = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (!rst_n) wn <= 0;
    else if (mem_wr && mem_addr[7:4] == 4'hA && wn < 16) begin
      wlog[wn] <= int'(mem_addr[3:0]);
      wn <= wn + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) an = 0;
    else for (int i = 0; i < 8; i++)
      if (irq_ack[i]) begin
        if (an < 16) alog[an] = i;
        an = an + 1;
        irq_req[i] = 1'b0;
        if (i < chain_max) irq_req[i+1] = 1'b1;
      end
  end

  localparam logic [7:0] LD = 8'h01, AD = 8'h02, ST = 8'h03, JP = 8'h04, RT = 8'h05;

  localparam logic [15:0] VEC [4][3] = '{
    '{16'h0003, 16'h0004, 16'h0007},
    '{16'h1234, 16'h1111, 16'h2345},
    '{16'hFFFF, 16'h0002, 16'h0001},
    '{16'h0000, 16'h0000, 16'h0000}
  };

  function automatic logic [15:0] ins(input logic [7:0] op, input logic [7:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) mem[a] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic irq_setup(input bit nm, input int cm);
    clear_mem();
    mem[8'h00] = ins(LD, 8'h80);
    mem[8'h01] = ins(ST, 8'h91);
    mem[8'h02] = ins(JP, 8'h01);
    mem[8'h80] = 16'h0005;
    for (int i = 0; i < 8; i++) begin
      mem[8'h40 + 4*i]     = ins(LD, 8'(8'hC0 + i));
      mem[8'h40 + 4*i + 1] = ins(ST, 8'(8'hA0 + i));
      mem[8'h40 + 4*i + 2] = ins(RT, 8'h00);
      mem[8'hC0 + i]       = 16'(16'h0010 + i);
    end
    nested_mode = nm;
    chain_max = cm;
    irq_req = '0;
    do_reset();
  endtask

  task automatic main_resumes(input string req);
    mem[8'h91] = 16'h0000;
    step(40);
    chk(req, int'(mem[8'h91]), 5);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) vec_tbl[i*8 +: 8] = 8'(8'h40 + 4*i);

    // R1 reset state, R3 stage timing, R4 pc advance
    clear_mem();
    mem[8'h00] = ins(ST, 8'h90);
    mem[8'h01] = ins(JP, 8'h01);
    do_reset();
    chk("R1 rd", int'(mem_rd), 1);
    chk("R1 addr", int'(mem_addr), 0);
    chk("R1 wr", int'(mem_wr), 0);
    chk("R1 ack", int'(irq_ack), 0);
    step(6);
    chk("R3 store cycle wr", int'(mem_wr), 1);
    chk("R3 store addr", int'(mem_addr), 8'h90);
    chk("R1 acc zero", int'(mem_wdata), 0);
    step(2);
    chk("R4 next fetch rd", int'(mem_rd), 1);
    chk("R4 next fetch addr", int'(mem_addr), 1);

    // R2 load/add/store vectors
    for (int v = 0; v < 4; v++) begin
      clear_mem();
      mem[8'h00] = ins(LD, 8'h80);
      mem[8'h01] = ins(AD, 8'h81);
      mem[8'h02] = ins(ST, 8'h90);
      mem[8'h03] = ins(JP, 8'h03);
      mem[8'h80] = VEC[v][0];
      mem[8'h81] = VEC[v][1];
      mem[8'h90] = 16'hBEEF;
      do_reset();
      step(3);
      chk("R3 operand read", int'(mem_rd && mem_addr == 8'h80), 1);
      step(40);
      chk("R2 sum", int'(mem[8'h90]), int'(VEC[v][2]));
    end

    // R4 jump, R7 empty return, R2 unknown opcode
    clear_mem();
    mem[8'h00] = ins(LD, 8'h80);
    mem[8'h01] = ins(RT, 8'h00);
    mem[8'h02] = 16'h7700;
    mem[8'h03] = ins(JP, 8'h06);
    mem[8'h04] = ins(ST, 8'h93);
    mem[8'h06] = ins(ST, 8'h94);
    mem[8'h07] = ins(JP, 8'h07);
    mem[8'h80] = 16'h0005;
    mem[8'h93] = 16'hDEAD;
    do_reset();
    step(80);
    chk("R4 jump skips", int'(mem[8'h93]), 16'hDEAD);
    chk("R7 empty return no effect", int'(mem[8'h94]), 5);

    // R5 priority select, sequential mode
    irq_setup(1'b0, 0);
    irq_req = 8'b0000_0101;
    step(300);
    chk("R5 writes", wn, 2);
    chk("R5 first high line", wlog[0], 2);
    chk("R5 second", wlog[1], 0);
    chk("R5 handler2 data", int'(mem[8'hA2]), 16'h12);
    chk("R6 ack cycles", an, 2);
    chk("R11 ack order", alog[0], 2);
    main_resumes("R7 main acc restored");

    // R8 sequential: request during handler waits
    irq_setup(1'b0, 1);
    irq_req = 8'b0000_0001;
    step(300);
    chk("R8 writes", wn, 2);
    chk("R8 order first", wlog[0], 0);
    chk("R8 order second", wlog[1], 1);
    main_resumes("R8 main resumes");

    // R9 nested: higher preempts
    irq_setup(1'b1, 1);
    irq_req = 8'b0000_0001;
    step(300);
    chk("R9 writes", wn, 2);
    chk("R9 preempt first", wlog[0], 1);
    chk("R9 resumed second", wlog[1], 0);
    chk("R9 handler0 acc intact", int'(mem[8'hA0]), 16'h10);
    main_resumes("R9 main resumes");

    // R10 stack overflow held
    irq_setup(1'b1, 4);
    irq_req = 8'b0000_0001;
    step(500);
    chk("R10 writes", wn, 5);
    chk("R10 w0", wlog[0], 3);
    chk("R10 w1 held line", wlog[1], 4);
    chk("R10 w2", wlog[2], 2);
    chk("R10 w3", wlog[3], 1);
    chk("R10 w4", wlog[4], 0);
    chk("R11 acks", an, 5);
    chk("R11 last ack", alog[4], 4);
    chk("R10 handler4 data", int'(mem[8'hA4]), 16'h14);
    main_resumes("R10 main resumes");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule